// File: doc/BRIEF.md
# Row-Fetch Frame Filter Sequencer

This block walks a whole image frame, one output row at a time, and moves pixel rows between memory and a small on-chip line store. A one-cycle start pulse launches a run. It carries a source base and a destination base, both given as byte addresses. For every output row, the sequencer decides which source rows it still needs. It fetches them with row-length burst reads into a set of three rotating row buffers. It then spends one cycle per column producing a result into a row-wide result buffer. Finally it stores that buffer with one row-length burst write.

The filter arithmetic is a pass-through hook. An interior result pixel is the centre word of the 3x3 window, taken from the buffer that holds the current row. Result pixels on the frame border are zero. At the end of the frame the block raises a level done flag and a one-cycle interrupt.

The memory side is a plain word-addressed request interface with separate read and write ports. Each burst is one request with a fixed length of one row, and the request is accepted by a grant. Read data returns with a valid strobe. Write data leaves under a ready handshake, and the burst closes with an acknowledge.

Top module: `frame_row_sequencer`

## Requirements
- R1: While reset is applied and right after it is released, rd_req_o, wr_req_o, wr_valid_o, done_o and irq_o are all low.
- R2: Both base addresses are byte addresses. The word base is the byte address shifted right by two, so the two low bits are dropped.
- R3: At output row 1 the block issues three read bursts, for source rows 0, 1 and 2, in that order. Each one has its own grant and WIDTH data beats.
- R4: At each interior row y from 2 to HEIGHT-2, exactly one read burst is issued, for source row y+1. Rows 0 and HEIGHT-1 issue no read, so one frame performs exactly HEIGHT read bursts.
- R5: For interior pixels (0<y<HEIGHT-1, 0<x<WIDTH-1), output pixel (y,x) equals source word (y,x). This holds through the buffer rotation: a new row overwrites the buffer that holds the oldest row. The row-select counter starts at 0, steps once per finished row, and wraps from 3 to 1.
- R6: The block writes every output row as one burst of WIDTH words. The burst address is dst_word + y*WIDTH, and rows go out in ascending order from 0 to HEIGHT-1. A read burst address is src_word + r*WIDTH.
- R7: Output rows 0 and HEIGHT-1, and output columns 0 and WIDTH-1, are written as zero.
- R8: A row's write request appears only after all of that row's read beats have arrived and WIDTH compute cycles have passed. A read request is never raised while a write request or write data is active.
- R9: One cycle after the acknowledge of the last row's write, done_o is high and irq_o pulses for exactly one cycle. done_o then stays high until the next accepted start, which clears it.
- R10: A start pulse that arrives while a frame is in progress is ignored. It changes neither the bases nor the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted only when idle or done |
| src_base_i | input | ADDR_W | Source frame base, byte address |
| dst_base_i | input | ADDR_W | Destination frame base, byte address |
| rd_req_o | output | 1 | Read burst request (WIDTH words) |
| rd_addr_o | output | ADDR_W | Read burst start word address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_data_i | input | DATA_W | Read data beat |
| wr_req_o | output | 1 | Write burst request (WIDTH words) |
| wr_addr_o | output | ADDR_W | Write burst start word address |
| wr_gnt_i | input | 1 | Write request accepted |
| wr_valid_o | output | 1 | Write data beat valid |
| wr_data_o | output | DATA_W | Write data beat |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_ack_i | input | 1 | Write burst completed |
| done_o | output | 1 | Frame finished, level |
| irq_o | output | 1 | Frame finished, one-cycle pulse |

## Verification
The bench uses a frame seven rows tall, so the row-select counter wraps at least once. It runs three frames:

- **Unaligned bases.** The first frame uses directed, unaligned byte bases. This separates a correct byte-to-word conversion from one that keeps the low bits.
- **Randomised handshakes.** The other two frames use random bases with random grant, data-gap, ready and acknowledge delays. These show that the sequence is set by the handshakes and not by fixed timing.
- **Start while busy.** One frame injects a start pulse with different bases in the middle of the priming reads.

Each source word is a hash of its absolute address with a per-frame salt. A wrong rotation, a wrong row address or a wrong burst target therefore shows up as a data mismatch in a specific row and column. Border zeros are checked apart from the interior.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  localparam int NUM_ROWS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME_READ,
    ST_ROW_READ,
    ST_COMPUTE,
    ST_ROW_WRITE,
    ST_DONE
  } ffs_state_e;
endpackage

// File: rtl/ffs_line_sel.sv
module ffs_line_sel (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       adv_i,
  output logic [1:0] top_o,
  output logic [1:0] mid_o,
  output logic [1:0] bot_o
);
  logic [1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= 2'd0;
    else if (clear_i) sel_q <= 2'd0;
    else if (adv_i)   sel_q <= (sel_q == 2'd3) ? 2'd1 : sel_q + 2'd1;
  end

  always_comb begin
    unique case (sel_q)
      2'd2:    begin top_o = 2'd1; mid_o = 2'd2; bot_o = 2'd0; end
      2'd3:    begin top_o = 2'd2; mid_o = 2'd0; bot_o = 2'd1; end
      default: begin top_o = 2'd0; mid_o = 2'd1; bot_o = 2'd2; end
    endcase
  end

  assert_sel_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clear_i && sel_q == 2'd3) |=> (sel_q == 2'd1));
  assert_sel_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clear_i) |=> (sel_q != 2'd0));
  assert_sel_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sel_q == 2'd0));
endmodule

// File: rtl/ffs_line_store.sv
module ffs_line_store import ffs_pkg::*; #(
  parameter  int WIDTH  = 800,
  parameter  int DATA_W = 32,
  localparam int XW     = $clog2(WIDTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [1:0]        buf_sel_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [XW-1:0]     idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              res_we_i,
  input  logic              res_keep_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] row_word [NUM_ROWS];
  logic [DATA_W-1:0] res_mem  [WIDTH];
  logic [DATA_W-1:0] centre;

  for (genvar b = 0; b < NUM_ROWS; b++) begin : g_row
    logic [DATA_W-1:0] mem [WIDTH];
    always_ff @(posedge clk_i) begin
      if (buf_we_i && buf_sel_i == 2'(b)) mem[idx_i] <= data_i;
    end
    assign row_word[b] = mem[idx_i];
  end

  // pass-through hook: centre tap of the window
  assign centre = (rd_sel_i < 2'(NUM_ROWS)) ? row_word[rd_sel_i] : '0;

  always_ff @(posedge clk_i) begin
    if (res_we_i) res_mem[idx_i] <= res_keep_i ? centre : '0;
  end

  assign res_o = res_mem[idx_i];

  assert_buf_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> (buf_sel_i < 2'(NUM_ROWS) && int'(idx_i) < WIDTH));
  assert_res_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_i |-> (int'(idx_i) < WIDTH && rd_sel_i < 2'(NUM_ROWS)));
endmodule

// File: rtl/ffs_ctrl.sv
module ffs_ctrl import ffs_pkg::*; #(
  parameter  int WIDTH  = 800,
  parameter  int HEIGHT = 600,
  parameter  int ADDR_W = 32,
  localparam int XW     = $clog2(WIDTH),
  localparam int YW     = $clog2(HEIGHT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  input  logic              wr_gnt_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  input  logic              wr_ack_i,
  output logic              done_o,
  output logic              irq_o,
  input  logic [1:0]        bot_i,
  output logic              sel_clear_o,
  output logic              sel_adv_o,
  output logic              buf_we_o,
  output logic [1:0]        buf_sel_o,
  output logic [XW-1:0]     idx_o,
  output logic              res_we_o,
  output logic              res_keep_o
);
  localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(HEIGHT - 1);

  ffs_state_e        state_q;
  logic [YW-1:0]     y_q;
  logic [XW-1:0]     x_q;
  logic [1:0]        prime_q;
  logic              issued_q, wait_ack_q, done_q, irq_q;
  logic [ADDR_W-1:0] src_w_q, dst_w_q;
  logic [YW-1:0]     rd_row;
  logic              last_x, last_y, rd_phase, idle_like;

  function automatic ffs_state_e row_entry(input logic [YW-1:0] y);
    if (y == '0 || y == Y_LAST) return ST_COMPUTE;
    else if (y == YW'(1))       return ST_PRIME_READ;
    else                        return ST_ROW_READ;
  endfunction

  assign last_x    = (x_q == X_LAST);
  assign last_y    = (y_q == Y_LAST);
  assign rd_phase  = (state_q == ST_PRIME_READ) || (state_q == ST_ROW_READ);
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      y_q        <= '0;
      x_q        <= '0;
      prime_q    <= '0;
      issued_q   <= 1'b0;
      wait_ack_q <= 1'b0;
      done_q     <= 1'b0;
      irq_q      <= 1'b0;
      src_w_q    <= '0;
      dst_w_q    <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            src_w_q    <= src_base_i >> 2;
            dst_w_q    <= dst_base_i >> 2;
            y_q        <= '0;
            x_q        <= '0;
            prime_q    <= '0;
            issued_q   <= 1'b0;
            wait_ack_q <= 1'b0;
            done_q     <= 1'b0;
            state_q    <= row_entry('0);
          end
        end
        ST_PRIME_READ, ST_ROW_READ: begin
          if (!issued_q) begin
            if (rd_gnt_i) issued_q <= 1'b1;
          end else if (rd_valid_i) begin
            if (last_x) begin
              x_q      <= '0;
              issued_q <= 1'b0;
              if (state_q == ST_PRIME_READ && prime_q != 2'd2) prime_q <= prime_q + 2'd1;
              else state_q <= ST_COMPUTE;
            end else begin
              x_q <= x_q + 1'b1;
            end
          end
        end
        ST_COMPUTE: begin
          if (last_x) begin
            x_q     <= '0;
            state_q <= ST_ROW_WRITE;
          end else begin
            x_q <= x_q + 1'b1;
          end
        end
        ST_ROW_WRITE: begin
          if (wait_ack_q) begin
            if (wr_ack_i) begin
              wait_ack_q <= 1'b0;
              issued_q   <= 1'b0;
              if (last_y) begin
                state_q <= ST_DONE;
                done_q  <= 1'b1;
                irq_q   <= 1'b1;
              end else begin
                y_q     <= y_q + 1'b1;
                state_q <= row_entry(y_q + 1'b1);
              end
            end
          end else if (!issued_q) begin
            if (wr_gnt_i) issued_q <= 1'b1;
          end else if (wr_ready_i) begin
            if (last_x) begin
              x_q        <= '0;
              wait_ack_q <= 1'b1;
            end else begin
              x_q <= x_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_row      = (state_q == ST_PRIME_READ) ? YW'(prime_q) : y_q + 1'b1;
  assign rd_addr_o   = src_w_q + ADDR_W'(rd_row) * ADDR_W'(WIDTH);
  assign wr_addr_o   = dst_w_q + ADDR_W'(y_q) * ADDR_W'(WIDTH);
  assign rd_req_o    = rd_phase && !issued_q;
  assign wr_req_o    = (state_q == ST_ROW_WRITE) && !issued_q && !wait_ack_q;
  assign wr_valid_o  = (state_q == ST_ROW_WRITE) && issued_q && !wait_ack_q;
  assign buf_we_o    = rd_phase && issued_q && rd_valid_i;
  assign buf_sel_o   = (state_q == ST_PRIME_READ) ? prime_q : bot_i;
  assign idx_o       = x_q;
  assign res_we_o    = (state_q == ST_COMPUTE);
  assign res_keep_o  = !(y_q == '0 || last_y || x_q == '0 || last_x);
  assign sel_clear_o = idle_like && start_i;
  assign sel_adv_o   = (state_q == ST_ROW_WRITE) && wait_ack_q && wr_ack_i;
  assign done_o      = done_q;
  assign irq_o       = irq_q;

  assert_no_rd_on_border_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (y_q != '0 && y_q != Y_LAST));
  assert_port_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, wr_req_o, wr_valid_o}));
  assert_write_after_compute_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_req_o) |-> ($past(state_q) == ST_COMPUTE));
  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_like && start_i) |=> ($stable(src_w_q) && $stable(dst_w_q)));
endmodule

// File: rtl/frame_row_sequencer.sv
module frame_row_sequencer #(
  parameter int WIDTH  = 800,
  parameter int HEIGHT = 600,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  input  logic              wr_gnt_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  input  logic              wr_ack_i,
  output logic              done_o,
  output logic              irq_o
);
  localparam int XW = $clog2(WIDTH);

  logic [1:0]    top_sel, mid_sel, bot_sel, buf_sel;
  logic          sel_clear, sel_adv, buf_we, res_we, res_keep;
  logic [XW-1:0] idx;

  ffs_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .src_base_i, .dst_base_i,
    .rd_req_o, .rd_addr_o, .rd_gnt_i, .rd_valid_i,
    .wr_req_o, .wr_addr_o, .wr_gnt_i, .wr_valid_o, .wr_ready_i, .wr_ack_i,
    .done_o, .irq_o,
    .bot_i(bot_sel), .sel_clear_o(sel_clear), .sel_adv_o(sel_adv),
    .buf_we_o(buf_we), .buf_sel_o(buf_sel), .idx_o(idx),
    .res_we_o(res_we), .res_keep_o(res_keep)
  );

  ffs_line_sel u_sel (
    .clk_i, .rst_ni, .clear_i(sel_clear), .adv_i(sel_adv),
    .top_o(top_sel), .mid_o(mid_sel), .bot_o(bot_sel)
  );

  ffs_line_store #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .buf_we_i(buf_we), .buf_sel_i(buf_sel), .rd_sel_i(mid_sel),
    .idx_i(idx), .data_i(rd_data_i), .res_we_i(res_we), .res_keep_i(res_keep),
    .res_o(wr_data_o)
  );

  assert_sel_distinct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we |-> (top_sel != mid_sel && mid_sel != bot_sel && top_sel != bot_sel));
endmodule

// File: tb/tb_frame_row_sequencer.sv
`timescale 1ns/1ps
module tb_frame_row_sequencer;
  localparam int W = 8;
  localparam int H = 7;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_base_i = '0, dst_base_i = '0;
  logic        rd_req_o, rd_gnt_i = 1'b0, rd_valid_i = 1'b0;
  logic [31:0] rd_addr_o, rd_data_i = '0;
  logic        wr_req_o, wr_gnt_i = 1'b0, wr_valid_o, wr_ready_i = 1'b0, wr_ack_i = 1'b0;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        done_o, irq_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int rd_cnt, wr_cnt, last_rd_cyc;
  logic [31:0] salt, srcw, dstw;
  logic [31:0] got [W];
  bit inject, first_frame;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_row_sequencer #(.WIDTH(W), .HEIGHT(H), .DATA_W(32), .ADDR_W(32)) dut (
    .clk_i(clk), .rst_ni, .start_i, .src_base_i, .dst_base_i,
    .rd_req_o, .rd_addr_o, .rd_gnt_i, .rd_valid_i, .rd_data_i,
    .wr_req_o, .wr_addr_o, .wr_gnt_i, .wr_valid_o, .wr_data_o, .wr_ready_i, .wr_ack_i,
    .done_o, .irq_o
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] src_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ salt;
  endfunction

  function automatic logic [31:0] exp_pix(input int y, input int x);
    if (y == 0 || y == H-1 || x == 0 || x == W-1) return 32'h0;
    return src_val(srcw + 32'(y*W + x));
  endfunction

  function automatic int exp_reads(input int y);
    if (y == 0) return 0;
    if (y == H-1) return H;
    return y + 2;
  endfunction

  task automatic serve_read();
    logic [31:0] a = rd_addr_o;
    chk(rd_cnt < 3 ? "R3" : "R4", "read row address", a, srcw + 32'(rd_cnt*W));
    if (first_frame && rd_cnt == 0) chk("R2", "byte to word source base", a, 32'h0000_0400);
    if (inject && rd_cnt == 2) begin
      start_i = 1'b1; src_base_i = $urandom; dst_base_i = $urandom;
      @(negedge clk); start_i = 1'b0;
      chk("R10", "read address after busy start", rd_addr_o, a);
      chk("R10", "request held after busy start", 32'(rd_req_o), 32'd1);
    end
    repeat ($urandom_range(0, 2)) @(negedge clk);
    rd_gnt_i = 1'b1; @(negedge clk); rd_gnt_i = 1'b0;
    for (int b = 0; b < W; b++) begin
      repeat ($urandom_range(0, 1)) @(negedge clk);
      rd_valid_i = 1'b1; rd_data_i = src_val(a + 32'(b));
      last_rd_cyc = cyc + 1;
      @(negedge clk);
      rd_valid_i = 1'b0;
    end
    rd_cnt++;
  endtask

  task automatic serve_write();
    int y = wr_cnt, beat = 0, tries = 0;
    bit r;
    chk("R6", "write row address", wr_addr_o, dstw + 32'(y*W));
    chk("R4", "reads done before row write", 32'(rd_cnt), 32'(exp_reads(y)));
    if (y > 0 && y < H-1)
      chk("R8", "compute gap after last read beat", 32'(cyc - last_rd_cyc >= W), 32'd1);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    wr_gnt_i = 1'b1; @(negedge clk); wr_gnt_i = 1'b0;
    while (beat < W && tries < 200) begin
      r = (tries % 4 == 3) ? 1'b1 : 1'($urandom_range(0, 1));
      if (wr_valid_o && r) begin got[beat] = wr_data_o; beat++; end
      wr_ready_i = r;
      @(negedge clk);
      tries++;
    end
    wr_ready_i = 1'b0;
    chk("R6", "beats in row burst", 32'(beat), 32'(W));
    chk("R8", "write data stops after burst", 32'(wr_valid_o), 32'd0);
    for (int x = 0; x < W; x++)
      chk((y == 0 || y == H-1 || x == 0 || x == W-1) ? "R7" : "R5",
          $sformatf("pixel y=%0d x=%0d", y, x), got[x], exp_pix(y, x));
    repeat ($urandom_range(0, 3)) @(negedge clk);
    wr_ack_i = 1'b1; @(negedge clk); wr_ack_i = 1'b0;
    wr_cnt++;
  endtask

  task automatic run_frame(input logic [31:0] sb, input logic [31:0] db, input bit inj, input bit first);
    inject = inj; first_frame = first;
    srcw = sb >> 2; dstw = db >> 2; salt = $urandom;
    rd_cnt = 0; wr_cnt = 0; last_rd_cyc = 0;
    @(negedge clk);
    src_base_i = sb; dst_base_i = db; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R9", "done cleared by new start", 32'(done_o), 32'd0);
    while (wr_cnt < H) begin
      if (rd_req_o)      serve_read();
      else if (wr_req_o) serve_write();
      else               @(negedge clk);
    end
    chk("R9", "done after last ack", 32'(done_o), 32'd1);
    chk("R9", "irq after last ack", 32'(irq_o), 32'd1);
    @(negedge clk);
    chk("R9", "irq one cycle only", 32'(irq_o), 32'd0);
    chk("R9", "done held", 32'(done_o), 32'd1);
    chk("R4", "read bursts per frame", 32'(rd_cnt), 32'(H));
    repeat (3) @(negedge clk);
    chk("R9", "done still held", 32'(done_o), 32'd1);
    chk("R4", "no read after frame", 32'(rd_req_o), 32'd0);
    chk("R6", "no write after frame", 32'(wr_req_o), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "rd_req in reset", 32'(rd_req_o), 32'd0);
    chk("R1", "done in reset", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset",
        32'({rd_req_o, wr_req_o, wr_valid_o, done_o, irq_o}), 32'd0);
    run_frame(32'h0000_1003, 32'h0000_8002, 1'b0, 1'b1);
    run_frame($urandom & 32'h00FF_FFFF, $urandom & 32'h00FF_FFFF, 1'b1, 1'b0);
    run_frame($urandom & 32'h00FF_FFFF, $urandom & 32'h00FF_FFFF, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule